// File: doc/BRIEF.md
# Bus SCAM Selection Responder

This block watches the open-collector control lines of a parallel SCSI-style bus for a SCAM selection attempt. An attempt is one specific pattern: SEL and MSG are both asserted at the moment BSY is released. The block looks for it only while software has set its enable bit. When it sees the pattern, it drives its own SEL and MSG lines. One cycle later it raises a processor interrupt. The interrupt is reported as a status pair with both bits set. The block does not decode a normal selection.

All three bus inputs are active low. Each passes through a synchronizer of two flops. A release of BSY is the rising edge of the synchronized BSY line. After the interrupt, software clears the enable bit, and the lines the block already drives stay asserted. Software then enters low-level mode, which hands both drives to two output-control bits. On detection the block presets both of those bits to one, so the handoff does not release either line. Software later releases MSG by clearing its output-control bit. It releases both lines by leaving low-level mode.

The controller is a state machine with five states:
- ST_IDLE: no drive.
- ST_WATCH: armed and looking for the pattern.
- ST_RESPOND: drives asserted for one cycle before the interrupt.
- ST_HELD: hardware holds both drives.
- ST_SOFT: the output-control bits drive the lines.

Its transitions are:
- arm: IDLE to WATCH when enabled and not in low-level mode.
- disarm: WATCH to IDLE when enable is cleared or low-level mode is set.
- detect: WATCH to RESPOND.
- report: RESPOND to HELD, which sets the status and the interrupt.
- handoff: HELD to SOFT, or IDLE to SOFT, when low-level mode is set.
- exit: SOFT to IDLE when low-level mode is cleared.

Top module: `scam_sel_responder`

## Requirements
- R1: After reset, sel_drv, msg_drv and irq are 0 and stat is 2'b00.
- R2: While the enable bit is clear, releasing BSY with SEL and MSG asserted causes no drive and no interrupt.
- R3: When enabled, a rising edge of bus_bsy_n while bus_sel_n and bus_msg_n are both low is an attempt.
  - sel_drv and msg_drv go to 1 after the third rising clock edge following the input change.
  - irq and stat = 2'b11 follow after the fourth rising clock edge.
- R4: A BSY release with SEL asserted but MSG not asserted causes no response.
- R5: SEL and MSG that become asserted after BSY is already released cause no response.
- R6: irq is 1 exactly when stat is 2'b11. The status stays set until a clear write with stat_clr_bits = 2'b11. A clear write with only one bit set has no effect.
- R7: Clearing the enable bit while the lines are held keeps sel_drv and msg_drv at 1.
- R8: Setting low-level mode while the lines are held moves control to ocl_sel and ocl_msg, which detection has preset to 1. Neither drive drops in any cycle of the handoff. A later write with ocl_msg = 0 releases msg_drv and leaves sel_drv at 1.
- R9: Clearing low-level mode returns the block to idle, and both drives read 0 one cycle after the write takes effect.
- R10: If a status clear write and a new status set fall on the same clock edge, the set wins and stat reads 2'b11.
- R11: An enable that is set and then cleared before an attempt leaves the block unarmed, so a later attempt causes no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_bsy_n | input | 1 | Sampled bus BSY, active low |
| bus_sel_n | input | 1 | Sampled bus SEL, active low |
| bus_msg_n | input | 1 | Sampled bus MSG, active low |
| ctrl_we | input | 1 | Write strobe for the control fields |
| ctrl_enable | input | 1 | Enable bit for selection response |
| ctrl_low_level | input | 1 | Low-level mode bit: software owns the drives |
| ocl_we | input | 1 | Write strobe for the output-control bits |
| ocl_sel | input | 1 | Output-control SEL drive bit |
| ocl_msg | input | 1 | Output-control MSG drive bit |
| stat_clr_we | input | 1 | Status clear strobe |
| stat_clr_bits | input | 2 | Write-one mask; only 2'b11 clears |
| sel_drv | output | 1 | SEL drive enable |
| msg_drv | output | 1 | MSG drive enable |
| irq | output | 1 | Selection interrupt |
| stat | output | 2 | Status pair; 2'b11 marks a selection |

## Verification
The status register can see two events on the same clock edge: a software clear of the status pair, and a new set from a detected attempt. The bench counts the cycles from the BSY release so that the clear write with mask 2'b11 is sampled on exactly the edge where the RESPOND-to-HELD transition sets the status. It then expects stat to read 2'b11 and irq to stay high. A second ordering check watches both drives on every cycle of the handoff and requires that neither drops when low-level mode takes over.

// File: rtl/scam_resp_pkg.sv
package scam_resp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WATCH,
        ST_RESPOND,
        ST_HELD,
        ST_SOFT
    } resp_state_e;

    typedef struct packed {
        logic bsy_n;
        logic sel_n;
        logic msg_n;
    } bus_lines_t;

endpackage

// File: rtl/scam_bus_sync.sv
module scam_bus_sync
    import scam_resp_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  bus_lines_t raw,
    output bus_lines_t synced
);
    localparam int unsigned LINES = $bits(bus_lines_t);

    logic [LINES-1:0] raw_v;
    logic [LINES-1:0] out_v;

    assign raw_v  = raw;
    assign synced = out_v;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe_q;
        // Bus lines idle released (high); reset there to avoid a false edge.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= {pipe_q[STAGES-2:0], raw_v[g]};
        end
        assign out_v[g] = pipe_q[STAGES-1];
    end

endmodule

// File: rtl/scam_sel_detect.sv
module scam_sel_detect
    import scam_resp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bus_lines_t synced,
    output logic       attempt
);
    logic bsy_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bsy_prev_q <= 1'b1;
        else        bsy_prev_q <= synced.bsy_n;
    end

    // Release = rising edge of the active-low BSY; SEL and MSG low at that moment.
    assign attempt = synced.bsy_n & ~bsy_prev_q & ~synced.sel_n & ~synced.msg_n;

endmodule

// File: rtl/scam_resp_regs.sv
module scam_resp_regs #(
    parameter int unsigned STAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              ctrl_enable,
    input  logic              ctrl_low_level,
    input  logic              ocl_we,
    input  logic              ocl_sel,
    input  logic              ocl_msg,
    input  logic              stat_clr_we,
    input  logic [STAT_W-1:0] stat_clr_bits,
    input  logic              set_evt,
    output logic              en_q,
    output logic              low_q,
    output logic              osel_q,
    output logic              omsg_q,
    output logic [STAT_W-1:0] stat_q
);
    localparam logic [STAT_W-1:0] SEL_CODE = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            low_q <= 1'b0;
        end else if (ctrl_we) begin
            en_q  <= ctrl_enable;
            low_q <= ctrl_low_level;
        end
    end

    // Detection presets both output-control bits so a later handoff keeps the lines.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osel_q <= 1'b0;
            omsg_q <= 1'b0;
        end else if (set_evt) begin
            osel_q <= 1'b1;
            omsg_q <= 1'b1;
        end else if (ocl_we) begin
            osel_q <= ocl_sel;
            omsg_q <= ocl_msg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                       stat_q <= '0;
        else if (set_evt)                                 stat_q <= SEL_CODE;
        else if (stat_clr_we && stat_clr_bits == SEL_CODE) stat_q <= '0;
    end

    p_stat_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == SEL_CODE && !(stat_clr_we && stat_clr_bits == SEL_CODE))
        |=> (stat_q == SEL_CODE));

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> (stat_q == SEL_CODE));

endmodule

// File: rtl/scam_resp_fsm.sv
module scam_resp_fsm
    import scam_resp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic low_lvl,
    input  logic attempt,
    input  logic osel,
    input  logic omsg,
    output logic sel_drv,
    output logic msg_drv,
    output logic set_evt
);
    resp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (low_lvl)  state_d = ST_SOFT;
                else if (en)  state_d = ST_WATCH;
            end
            ST_WATCH: begin
                if (!en || low_lvl) state_d = ST_IDLE;
                else if (attempt)   state_d = ST_RESPOND;
            end
            ST_RESPOND: state_d = ST_HELD;
            ST_HELD: begin
                if (low_lvl) state_d = ST_SOFT;
            end
            ST_SOFT: begin
                if (!low_lvl) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        sel_drv = 1'b0;
        msg_drv = 1'b0;
        set_evt = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_WATCH: ;
            ST_RESPOND: begin
                sel_drv = 1'b1;
                msg_drv = 1'b1;
                set_evt = 1'b1;
            end
            ST_HELD: begin
                sel_drv = 1'b1;
                msg_drv = 1'b1;
            end
            ST_SOFT: begin
                sel_drv = osel;
                msg_drv = omsg;
            end
            default: ;
        endcase
    end

    p_hold_while_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && !low_lvl) |=> (sel_drv && msg_drv));

    p_handoff_no_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && low_lvl && osel && omsg) |=> (sel_drv && msg_drv));

endmodule

// File: rtl/scam_sel_responder.sv
module scam_sel_responder
    import scam_resp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned STAT_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_bsy_n,
    input  logic              bus_sel_n,
    input  logic              bus_msg_n,
    input  logic              ctrl_we,
    input  logic              ctrl_enable,
    input  logic              ctrl_low_level,
    input  logic              ocl_we,
    input  logic              ocl_sel,
    input  logic              ocl_msg,
    input  logic              stat_clr_we,
    input  logic [STAT_W-1:0] stat_clr_bits,
    output logic              sel_drv,
    output logic              msg_drv,
    output logic              irq,
    output logic [STAT_W-1:0] stat
);
    bus_lines_t raw_s, sync_s;
    logic attempt, set_evt;
    logic en_q, low_q, osel_q, omsg_q;

    assign raw_s.bsy_n = bus_bsy_n;
    assign raw_s.sel_n = bus_sel_n;
    assign raw_s.msg_n = bus_msg_n;

    scam_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(raw_s), .synced(sync_s)
    );

    scam_sel_detect u_detect (
        .clk(clk), .rst_n(rst_n), .synced(sync_s), .attempt(attempt)
    );

    scam_resp_regs #(.STAT_W(STAT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_enable(ctrl_enable), .ctrl_low_level(ctrl_low_level),
        .ocl_we(ocl_we), .ocl_sel(ocl_sel), .ocl_msg(ocl_msg),
        .stat_clr_we(stat_clr_we), .stat_clr_bits(stat_clr_bits),
        .set_evt(set_evt),
        .en_q(en_q), .low_q(low_q), .osel_q(osel_q), .omsg_q(omsg_q),
        .stat_q(stat)
    );

    scam_resp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .en(en_q), .low_lvl(low_q), .attempt(attempt),
        .osel(osel_q), .omsg(omsg_q),
        .sel_drv(sel_drv), .msg_drv(msg_drv), .set_evt(set_evt)
    );

    assign irq = &stat;

    p_irq_after_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(sel_drv) && $past(msg_drv)));

    p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !low_q && !sel_drv && !msg_drv) |=> (!sel_drv && !msg_drv));

endmodule

// File: tb/scam_sel_responder_tb.sv
module scam_sel_responder_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_bsy_n = 1'b1, bus_sel_n = 1'b1, bus_msg_n = 1'b1;
    logic ctrl_we = 1'b0, ctrl_enable = 1'b0, ctrl_low_level = 1'b0;
    logic ocl_we = 1'b0, ocl_sel = 1'b0, ocl_msg = 1'b0;
    logic stat_clr_we = 1'b0;
    logic [1:0] stat_clr_bits = 2'b00;
    logic sel_drv, msg_drv, irq;
    logic [1:0] stat;

    int n_checks = 0;
    int n_fail = 0;

    always #10ns clk = ~clk;

    scam_sel_responder dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_bsy_n(bus_bsy_n), .bus_sel_n(bus_sel_n), .bus_msg_n(bus_msg_n),
        .ctrl_we(ctrl_we), .ctrl_enable(ctrl_enable), .ctrl_low_level(ctrl_low_level),
        .ocl_we(ocl_we), .ocl_sel(ocl_sel), .ocl_msg(ocl_msg),
        .stat_clr_we(stat_clr_we), .stat_clr_bits(stat_clr_bits),
        .sel_drv(sel_drv), .msg_drv(msg_drv), .irq(irq), .stat(stat)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Packs {irq, stat, sel_drv, msg_drv} for compact comparison.
    function automatic logic [7:0] outs();
        return {3'b000, irq, stat, sel_drv, msg_drv};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        bus_bsy_n = 1'b1; bus_sel_n = 1'b1; bus_msg_n = 1'b1;
        ctrl_we = 1'b0; ocl_we = 1'b0; stat_clr_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic en, input logic low);
        ctrl_we = 1'b1; ctrl_enable = en; ctrl_low_level = low;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_ocl(input logic s, input logic m);
        ocl_we = 1'b1; ocl_sel = s; ocl_msg = m;
        @(negedge clk);
        ocl_we = 1'b0;
    endtask

    task automatic wr_clr(input logic [1:0] b);
        stat_clr_we = 1'b1; stat_clr_bits = b;
        @(negedge clk);
        stat_clr_we = 1'b0;
    endtask

    task automatic set_bus(input logic b, input logic s, input logic m);
        bus_bsy_n = b; bus_sel_n = s; bus_msg_n = m;
    endtask

    // Arms, presents SEL+MSG under BSY, releases BSY, checks the response timing.
    task automatic run_attempt(input bit collide);
        wr_ctrl(1'b1, 1'b0);
        set_bus(1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        set_bus(1'b1, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        chk("R3 no drive before third edge", outs(), 8'h00);
        @(negedge clk);
        chk("R3 drives up, no irq yet", outs(), 8'h03);
        if (collide) begin
            stat_clr_we = 1'b1; stat_clr_bits = 2'b11;
        end
        @(negedge clk);
        stat_clr_we = 1'b0;
        if (collide) chk("R10 set wins over clear", outs(), 8'h1f);
        else         chk("R3 R6 irq with stat 11", outs(), 8'h1f);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset outputs", outs(), 8'h00);
    endtask

    task automatic t_basic_and_clear();
        do_reset();
        run_attempt(1'b0);
        wr_clr(2'b01);
        chk("R6 partial clear ignored", outs(), 8'h1f);
        wr_clr(2'b10);
        chk("R6 other partial clear ignored", outs(), 8'h1f);
        wr_clr(2'b11);
        chk("R6 full clear drops irq, drives stay", outs(), 8'h03);
    endtask

    task automatic t_enable_off_hold();
        do_reset();
        run_attempt(1'b0);
        wr_ctrl(1'b0, 1'b0);
        repeat (5) @(negedge clk);
        chk("R7 drives held after enable cleared", outs(), 8'h1f);
    endtask

    task automatic t_handoff();
        do_reset();
        run_attempt(1'b0);
        wr_ctrl(1'b0, 1'b1);
        chk("R8 handoff cycle 1", {6'd0, sel_drv, msg_drv}, 8'h03);
        @(negedge clk);
        chk("R8 handoff cycle 2", {6'd0, sel_drv, msg_drv}, 8'h03);
        wr_ocl(1'b1, 1'b0);
        chk("R8 msg released by software", {6'd0, sel_drv, msg_drv}, 8'h02);
        wr_ctrl(1'b0, 1'b0);
        @(negedge clk);
        chk("R9 leaving low-level releases drives", {6'd0, sel_drv, msg_drv}, 8'h00);
    endtask

    task automatic t_disabled();
        do_reset();
        set_bus(1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        set_bus(1'b1, 1'b0, 1'b0);
        repeat (8) @(negedge clk);
        chk("R2 no response while disabled", outs(), 8'h00);
    endtask

    task automatic t_partial();
        do_reset();
        wr_ctrl(1'b1, 1'b0);
        set_bus(1'b0, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        set_bus(1'b1, 1'b0, 1'b1);
        repeat (8) @(negedge clk);
        chk("R4 SEL without MSG ignored", outs(), 8'h00);
    endtask

    task automatic t_late();
        do_reset();
        wr_ctrl(1'b1, 1'b0);
        set_bus(1'b0, 1'b1, 1'b1);
        repeat (4) @(negedge clk);
        set_bus(1'b1, 1'b1, 1'b1);
        repeat (4) @(negedge clk);
        set_bus(1'b1, 1'b0, 1'b0);
        repeat (8) @(negedge clk);
        chk("R5 SEL/MSG after release ignored", outs(), 8'h00);
    endtask

    task automatic t_disarm();
        do_reset();
        wr_ctrl(1'b1, 1'b0);
        repeat (3) @(negedge clk);
        wr_ctrl(1'b0, 1'b0);
        set_bus(1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        set_bus(1'b1, 1'b0, 1'b0);
        repeat (8) @(negedge clk);
        chk("R11 disarmed block ignores attempt", outs(), 8'h00);
    endtask

    task automatic t_collide();
        do_reset();
        run_attempt(1'b1);
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_basic_and_clear();
        t_enable_off_hold();
        t_handoff();
        t_disabled();
        t_partial();
        t_late();
        t_disarm();
        t_collide();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule